// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block holds the software-generated interrupt (SGI) state of a small multiprocessor interrupt distributor serving up to eight CPUs, each with sixteen SGI IDs. A CPU raises an SGI by writing a 32-bit word to a generate register. The word names the SGI ID, a target list and a filter mode. For every CPU the write selects, the block records the requester as a sender of that SGI. For every (target CPU, SGI ID) pair the block keeps an 8-bit sender bitmap. The pair is pending whenever its bitmap is non-zero.

Two banked byte windows give each CPU direct access to its own sender bitmaps. Writes to the set window OR bits into the bitmaps. Writes to the clear window remove bits from them. Reads of either window return the bitmaps. Every access carries the accessing CPU's ID. A static input gives the number of online CPUs. The outputs are the full pending matrix and a per-CPU summary bit. Prioritisation, acknowledge and delivery happen downstream.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, every sender bitmap is zero, `pendVec` and `cpuPend` are zero, and window reads return zero.
- R2: A word write (`busSize`=1) to the generate region (`busAddr[5:4]`=00) uses SGI ID in bits [3:0], target list in bits [23:16] and mode in bits [25:24]. In mode 0, each listed CPU whose index is below `onlineCnt` gets the requester's bit (bit `busCpu`) set in its bitmap for that SGI. The update is visible on the outputs after the next rising clock edge. Listed CPUs at or above `onlineCnt` are unaffected.
- R3: Mode 1 targets every CPU below `onlineCnt` except the requester. The target list is ignored.
- R4: Mode 2 targets only the requester. The target list is ignored.
- R5: A mode 3 write to the generate region changes no state.
- R6: The generate region reads as zero. A byte write (`busSize`=0) to it changes no state.
- R7: A write to the set window (`busAddr[5:4]`=01) ORs data into the accessing CPU's bitmaps. A byte access uses `busWdata[7:0]` for SGI `busAddr[3:0]`. A word access sends byte lane k to SGI `{busAddr[3:2],2'b00}`+k. A resulting non-zero bitmap is pending. A zero byte changes nothing.
- R8: A write to the clear window (`busAddr[5:4]`=10) removes the written bits from the accessing CPU's bitmaps, using the same lane mapping as R7. Pending clears only when the bitmap becomes empty.
- R9: A read of either window returns the accessing CPU's bitmaps with the same lane mapping as R7, combinationally in the same cycle. A byte read places the value in `busRdata[7:0]` with the upper bits zero.
- R10: `pendVec[c*16+s]` is the pending bit of SGI s at CPU c. `cpuPend[c]` is the OR of CPU c's sixteen pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| onlineCnt | input | 4 | Number of online CPUs, 1 to 8, static |
| busValid | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 1 | 1 = 32-bit, 0 = 8-bit |
| busAddr | input | 6 | Byte address: [5:4] region, [3:0] offset |
| busCpu | input | 3 | ID of the accessing CPU |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| pendVec | output | 128 | Pending matrix, CPU-major |
| cpuPend | output | 8 | Per-CPU pending summary |

## Verification
The assertions assume that `busCpu` names an online CPU, that `onlineCnt` holds a value from 1 to 8 and changes only while reset is held, and that a word access carries zero in `busAddr[1:0]`. The mode 2 and offline-CPU properties rely on these assumptions. The stimulus issues requests only from CPUs below the programmed count. It changes the count only across a fresh reset and aligns every word address.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  parameter int NUM_CPUS = 8;
  parameter int NUM_SGIS = 16;
  parameter int LANES    = 4;
  parameter int MODE_LSB = 24;
  parameter int LIST_LSB = 16;

  localparam int CPU_W  = $clog2(NUM_CPUS);
  localparam int SGI_W  = $clog2(NUM_SGIS);
  localparam int CNT_W  = $clog2(NUM_CPUS + 1);
  localparam int ADDR_W = SGI_W + 2;
  localparam int DATA_W = LANES * NUM_CPUS;
  localparam int PEND_W = NUM_CPUS * NUM_SGIS;

  typedef enum logic [1:0] {
    REG_GEN  = 2'b00,
    REG_SET  = 2'b01,
    REG_CLR  = 2'b10,
    REG_NONE = 2'b11
  } region_e;

  typedef enum logic [1:0] {
    FLT_LIST  = 2'd0,
    FLT_OTHER = 2'd1,
    FLT_SELF  = 2'd2,
    FLT_RSVD  = 2'd3
  } filter_e;

  typedef struct packed {
    logic                genWr;
    logic                setWr;
    logic                clrWr;
    logic                rdWin;
    logic [LANES-1:0]    laneEn;
    logic [SGI_W-1:0]    baseSgi;
    logic [NUM_CPUS-1:0] targets;
    logic [CPU_W-1:0]    reqCpu;
  } strobe_t;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CPU_W-1:0]  busCpu,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  onlineCnt,
  output strobe_t           ctl
);
  region_e             region;
  filter_e             mode;
  logic [NUM_CPUS-1:0] onlineMask;
  logic [NUM_CPUS-1:0] selfMask;
  logic [NUM_CPUS-1:0] listMask;
  logic [SGI_W-1:0]    winBase;

  assign region   = region_e'(busAddr[ADDR_W-1 -: 2]);
  assign mode     = filter_e'(busWdata[MODE_LSB +: 2]);
  assign selfMask = NUM_CPUS'(1) << busCpu;
  assign listMask = busWdata[LIST_LSB +: NUM_CPUS];
  assign winBase  = busSize ? (busAddr[SGI_W-1:0] & ~SGI_W'(LANES - 1))
                            : busAddr[SGI_W-1:0];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : gOnline
    assign onlineMask[c] = CNT_W'(c) < onlineCnt;
  end

  always_comb begin
    ctl         = '0;
    ctl.reqCpu  = busCpu;
    ctl.laneEn  = busSize ? {LANES{1'b1}} : LANES'(1);
    ctl.baseSgi = (region == REG_GEN) ? busWdata[SGI_W-1:0] : winBase;
    unique case (mode)
      FLT_LIST:  ctl.targets = listMask & onlineMask;
      FLT_OTHER: ctl.targets = onlineMask & ~selfMask;
      FLT_SELF:  ctl.targets = selfMask & onlineMask;
      default:   ctl.targets = '0;
    endcase
    ctl.genWr = busValid && busWrite && busSize && (region == REG_GEN) && (mode != FLT_RSVD);
    ctl.setWr = busValid && busWrite && (region == REG_SET);
    ctl.clrWr = busValid && busWrite && (region == REG_CLR);
    ctl.rdWin = busValid && !busWrite && ((region == REG_SET) || (region == REG_CLR));
  end

  always_comb begin
    if (ctl.genWr) begin
      AST_GEN_EXCLUSIVE: assert (!ctl.setWr && !ctl.clrWr); // R2
    end
  end
endmodule

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [PEND_W-1:0] pendVec
);
  logic [NUM_CPUS-1:0][NUM_SGIS-1:0][NUM_CPUS-1:0] srcMap, srcNxt;

  always_comb begin
    srcNxt = srcMap;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int s = 0; s < NUM_SGIS; s++) begin
        if (ctl.genWr && ctl.targets[c] && (SGI_W'(s) == ctl.baseSgi))
          srcNxt[c][s][ctl.reqCpu] = 1'b1;
        for (int l = 0; l < LANES; l++) begin
          if ((CPU_W'(c) == ctl.reqCpu) && ctl.laneEn[l] &&
              (SGI_W'(s) == ctl.baseSgi + SGI_W'(l))) begin
            if (ctl.setWr) srcNxt[c][s] = srcNxt[c][s] | busWdata[l*NUM_CPUS +: NUM_CPUS];
            if (ctl.clrWr) srcNxt[c][s] = srcNxt[c][s] & ~busWdata[l*NUM_CPUS +: NUM_CPUS];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) srcMap <= '0;
    else       srcMap <= srcNxt;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : gCpu
    for (genvar s = 0; s < NUM_SGIS; s++) begin : gSgi
      assign pendVec[c*NUM_SGIS + s] = |srcMap[c][s];
    end
  end

  always_comb begin
    busRdata = '0;
    if (ctl.rdWin) begin
      for (int l = 0; l < LANES; l++) begin
        if (ctl.laneEn[l])
          busRdata[l*NUM_CPUS +: NUM_CPUS] = srcMap[ctl.reqCpu][ctl.baseSgi + SGI_W'(l)];
      end
    end
  end

  AST_CLR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrWr && !ctl.setWr && !ctl.genWr && ctl.laneEn[0] && (&busWdata[NUM_CPUS-1:0]))
      |=> !pendVec[int'($past(ctl.reqCpu))*NUM_SGIS + int'($past(ctl.baseSgi))]); // R8
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  onlineCnt,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CPU_W-1:0]  busCpu,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [PEND_W-1:0] pendVec,
  output logic [NUM_CPUS-1:0] cpuPend
);
  strobe_t ctl;

  sgi_ctrl u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .busCpu   (busCpu),
    .busWdata (busWdata),
    .onlineCnt(onlineCnt),
    .ctl      (ctl)
  );

  sgi_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pendVec (pendVec)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : gSum
    assign cpuPend[c] = |pendVec[c*NUM_SGIS +: NUM_SGIS];
  end

  logic                genHit;
  logic [NUM_CPUS-1:0] offlineMask;
  assign genHit = busValid && busWrite && busSize && (busAddr[ADDR_W-1 -: 2] == REG_GEN);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : gOff
    assign offlineMask[c] = !(CNT_W'(c) < onlineCnt);
  end

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (genHit && busWdata[MODE_LSB +: 2] == FLT_RSVD) |=> $stable(pendVec)); // R5

  AST_SELF_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (genHit && busWdata[MODE_LSB +: 2] == FLT_SELF)
      |=> pendVec[int'($past(busCpu))*NUM_SGIS + int'($past(busWdata[SGI_W-1:0]))]); // R4

  AST_OFFLINE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    genHit |=> (((cpuPend ^ $past(cpuPend)) & offlineMask) == '0)); // R2

  AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !busSize && busAddr[ADDR_W-1 -: 2] == REG_SET &&
     busWdata[NUM_CPUS-1:0] != '0)
      |=> pendVec[int'($past(busCpu))*NUM_SGIS + int'($past(busAddr[SGI_W-1:0]))]); // R7

  AST_GEN_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr[ADDR_W-1 -: 2] == REG_GEN) |-> busRdata == '0); // R6
endmodule

// File: tb/sgi_dispatch_bench.sv
`timescale 1ns/1ps
module sgi_dispatch_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  onlineCnt = 4'd8;
  logic        busValid = 1'b0, busWrite = 1'b0, busSize = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [2:0]  busCpu = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [127:0] pendVec;
  logic [7:0]  cpuPend;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sgi_dispatch u_sgi_dispatch (
    .clk(clk), .rstN(rstN), .onlineCnt(onlineCnt), .busValid(busValid),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr), .busCpu(busCpu),
    .busWdata(busWdata), .busRdata(busRdata), .pendVec(pendVec), .cpuPend(cpuPend)
  );

  typedef struct packed {
    logic        sz;
    logic [5:0]  addr;
    logic [2:0]  cpu;
    logic [31:0] data;
    logic [7:0]  expPend;
    logic [7:0]  tag;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 6'h00, 3'd1, 32'h0005_0003, 8'h05, 8'd2},
    '{1'b1, 6'h00, 3'd0, 32'h0100_0005, 8'hFF, 8'd3},
    '{1'b1, 6'h00, 3'd2, 32'h0200_0007, 8'hFF, 8'd4},
    '{1'b1, 6'h00, 3'd3, 32'h03FF_0009, 8'hFF, 8'd5},
    '{1'b1, 6'h24, 3'd1, 32'h0000_FF00, 8'hFD, 8'd8},
    '{1'b1, 6'h20, 3'd0, 32'hFFFF_FFFF, 8'hFC, 8'd8},
    '{1'b0, 6'h1E, 3'd0, 32'h0000_0080, 8'hFD, 8'd7},
    '{1'b0, 6'h13, 3'd1, 32'h0000_0000, 8'hFD, 8'd7}
  };

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic sz, logic [5:0] addr, logic [2:0] cpu, logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busSize = sz;
    busAddr = addr; busCpu = cpu; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(logic sz, logic [5:0] addr, logic [2:0] cpu, output logic [31:0] val);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busSize = sz;
    busAddr = addr; busCpu = cpu; busWdata = '0;
    #1 val = busRdata;
    busValid = 1'b0;
  endtask

  task automatic applyReset(logic [3:0] cnt);
    @(negedge clk);
    rstN = 1'b0; onlineCnt = cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    applyReset(4'd8);
    check("R1 pendVec", pendVec, '0);
    check("R1 cpuPend", {120'b0, cpuPend}, '0);
    doRead(1'b1, 6'h10, 3'd0, rv);
    check("R1 read", {96'b0, rv}, '0);

    for (int i = 0; i < 8; i++) begin
      doWrite(VECS[i].sz, VECS[i].addr, VECS[i].cpu, VECS[i].data);
      check($sformatf("R%0d vec%0d cpuPend", VECS[i].tag, i), {120'b0, cpuPend}, {120'b0, VECS[i].expPend});
    end

    // R9: windows read back per accessing CPU
    doRead(1'b1, 6'h14, 3'd2, rv);
    check("R9 word set window", {96'b0, rv}, {96'b0, 32'h0400_0100});
    doRead(1'b1, 6'h20, 3'd2, rv);
    check("R9 word clear window", {96'b0, rv}, {96'b0, 32'h0200_0000});
    doRead(1'b0, 6'h13, 3'd2, rv);
    check("R9 byte read", {96'b0, rv}, {96'b0, 32'h0000_0002});
    doRead(1'b0, 6'h1E, 3'd0, rv);
    check("R7 set byte readback", {96'b0, rv}, {96'b0, 32'h0000_0080});
    doRead(1'b1, 6'h00, 3'd2, rv);
    check("R6 generate reads zero", {96'b0, rv}, '0);

    // R7/R8: partial clears keep pending until empty
    doWrite(1'b0, 6'h13, 3'd2, 32'h0000_0030);
    doWrite(1'b0, 6'h23, 3'd2, 32'h0000_0002);
    check("R8 partial clear pending", {127'b0, pendVec[2*16+3]}, 128'd1);
    doRead(1'b0, 6'h23, 3'd2, rv);
    check("R8 partial clear bitmap", {96'b0, rv}, {96'b0, 32'h0000_0030});
    doWrite(1'b0, 6'h23, 3'd2, 32'h0000_0030);
    check("R8 empty clears pending", {127'b0, pendVec[2*16+3]}, '0);
    check("R10 cpu2 summary", {127'b0, cpuPend[2]}, 128'd1);

    // R6: byte write to generate region ignored
    doWrite(1'b0, 6'h00, 3'd0, 32'h0000_0002);
    check("R6 byte gen ignored", {127'b0, pendVec[0*16+2]}, '0);

    // R2: multiple senders accumulate
    doWrite(1'b1, 6'h00, 3'd3, 32'h0001_0001);
    doWrite(1'b1, 6'h00, 3'd0, 32'h0001_0001);
    doRead(1'b0, 6'h11, 3'd0, rv);
    check("R2 sender bitmap", {96'b0, rv}, {96'b0, 32'h0000_0009});
    check("R10 pendVec index", {127'b0, pendVec[0*16+1]}, 128'd1);

    // Reduced online count
    applyReset(4'd4);
    check("R1 reset again", pendVec, '0);
    doWrite(1'b1, 6'h00, 3'd0, 32'h00FF_0001);
    check("R2 online mask", {120'b0, cpuPend}, {120'b0, 8'h0F});
    doWrite(1'b1, 6'h00, 3'd1, 32'h01F0_0002);
    check("R3 requester excluded", {127'b0, pendVec[1*16+2]}, '0);
    check("R3 other cpu set", {127'b0, pendVec[3*16+2]}, 128'd1);
    check("R3 offline untouched", {120'b0, cpuPend}, {120'b0, 8'h0F});
    doWrite(1'b1, 6'h00, 3'd1, 32'h0208_0006);
    check("R4 self only", {112'b0, pendVec[16 +: 16]}, {112'b0, 16'h0042});
    check("R4 list ignored", {127'b0, pendVec[3*16+6]}, '0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule